// File: doc/BRIEF.md
# Half-Precision Transfer and Boxing Unit

This unit moves 16-bit half-precision bit patterns between memory, the integer register file and a floating-point register file whose entries are FLEN bits wide. It serves four operations: a halfword load that writes a floating-point register, a halfword store that reads one, a move from a floating-point register to an integer register, and a move from an integer register to a floating-point register. Each request carries an operation code, a rounding field and a source value. One cycle later a registered result appears with a valid strobe.

Any result bound for the floating-point register file is NaN-boxed: every bit from 16 up to FLEN-1 is set to one. With FLEN = 64 this is the single-precision box nested inside the double-precision box. A result bound for the integer file is sign-filled from bit 15 up to XLEN-1. A store result carries only the low halfword. The 16 transferred bits are never changed, so NaN payloads of any form pass through as they are. Requests that cannot be decoded raise an illegal strobe. They leave the result register as it was.

Top module: `hp_xfer_unit`

## Requirements
- R1: Load (reqOp = 3'b000): one cycle later resData[15:0] equals srcData[15:0] and bits 16 through FLEN-1 are all one, whatever the upper source bits held.
- R2: Integer-to-float move (reqOp = 3'b011, reqRm = 3'b000): one cycle later resData[15:0] equals srcData[15:0] and bits 16 through FLEN-1 are all one. Source bits above 15 have no effect.
- R3: Store (reqOp = 3'b001): one cycle later resData[15:0] equals srcData[15:0] and every higher bit is zero. Source bits above 15 have no effect.
- R4: Float-to-integer move (reqOp = 3'b010, reqRm = 3'b000): one cycle later resData[15:0] equals srcData[15:0] and bits 16 through XLEN-1 are copies of srcData[15].
- R5: The 16 transferred bits are never altered by any operation. This includes signalling and quiet NaN patterns with arbitrary payloads and either sign.
- R6: A move (reqOp 3'b010 or 3'b011) whose reqRm is not 3'b000 is rejected. One cycle later illegal is 1 and resValid is 0, and resData keeps its previous value.
- R7: An undefined operation code (reqOp 3'b100 to 3'b111) is rejected in the same way as in R6: illegal is 1, resValid is 0 and resData is held.
- R8: resValid is 1 exactly one cycle after an accepted request. A cycle without reqValid yields resValid = 0 and illegal = 0 and holds resData. reqRm has no effect on load and store.
- R9: While rstN is low, resValid, illegal and resData are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code (see R1 to R4, R7) |
| reqRm | input | 3 | Rounding field of the instruction; must be zero for moves |
| srcData | input | max(XLEN,FLEN) | Source value: memory halfword or register contents |
| resValid | output | 1 | Result valid, one cycle after an accepted request |
| illegal | output | 1 | Rejected request, one cycle after it |
| resData | output | max(XLEN,FLEN) | Registered result |

## Verification
Several properties are checked on every cycle: the low halfword after any capture equals the captured source halfword, all box bits are set after a boxing capture, and the result holds whenever nothing is accepted. Valid and illegal never rise together, and a move with a nonzero rounding field always becomes an illegal strobe. Some behaviour can only be shown by the bench's scenarios. These are the exact sign fill for positive and negative halfwords, the zeroing of upper store bits while the source upper bits carry patterns, and the indifference of load and store to the rounding field. The same goes for preservation of particular NaN payloads and for back-to-back requests against a scoreboard.

// File: rtl/hp_xfer_pkg.sv
package hp_xfer_pkg;
  localparam logic [2:0] OP_LOAD   = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_MV_F2X = 3'b010;
  localparam logic [2:0] OP_MV_X2F = 3'b011;

  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    FILL_BOX  = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_ZERO = 2'd2
  } fill_e;

  typedef struct packed {
    logic  capture;
    fill_e fill;
  } dpCtrl_t;
endpackage

// File: rtl/hp_xfer_ctrl.sv
module hp_xfer_ctrl
  import hp_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic [2:0]  reqRm,
  output dpCtrl_t     dpCtrl,
  output logic        resValid,
  output logic        illegal
);
  logic isMove;
  logic opKnown;
  logic reqLegal;

  always_comb begin
    isMove   = (reqOp == OP_MV_F2X) || (reqOp == OP_MV_X2F);
    opKnown  = (reqOp[2] == 1'b0);
    reqLegal = opKnown && !(isMove && (reqRm != 3'b000));

    dpCtrl.capture = reqValid && reqLegal;
    unique case (reqOp)
      OP_STORE:  dpCtrl.fill = FILL_ZERO;
      OP_MV_F2X: dpCtrl.fill = FILL_SIGN;
      default:   dpCtrl.fill = FILL_BOX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= reqValid && reqLegal;
      illegal  <= reqValid && !reqLegal;
    end
  end

  // R8
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(reqValid));

  // R6
  valid_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && illegal));

  // R6
  move_rm_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqOp == OP_MV_F2X || reqOp == OP_MV_X2F) && reqRm != 3'b000)
      |=> (illegal && !resValid));

  // R7
  undef_op_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp[2]) |=> (illegal && !resValid));
endmodule

// File: rtl/hp_xfer_dp.sv
module hp_xfer_dp
  import hp_xfer_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 64,
  localparam int WIDE = (XLEN > FLEN) ? XLEN : FLEN
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         dpCtrl,
  input  logic [WIDE-1:0] srcData,
  output logic [WIDE-1:0] resData
);
  logic [WIDE-1:0] nextData;
  logic            signBit;

  assign signBit = srcData[HALF_W-1];

  always_comb begin
    nextData = resData;
    if (dpCtrl.capture) begin
      for (int i = 0; i < WIDE; i++) begin
        if (i < HALF_W) begin
          nextData[i] = srcData[i];
        end else begin
          unique case (dpCtrl.fill)
            FILL_BOX:  nextData[i] = (i < FLEN);
            FILL_SIGN: nextData[i] = (i < XLEN) ? signBit : 1'b0;
            default:   nextData[i] = 1'b0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) resData <= '0;
    else       resData <= nextData;
  end

  // R5
  halfword_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |=> (resData[HALF_W-1:0] == HALF_W'($past(srcData))));

  // R1
  box_bits_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.capture && dpCtrl.fill == FILL_BOX) |=> (&resData[FLEN-1:HALF_W]));

  // R3
  store_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.capture && dpCtrl.fill == FILL_ZERO) |=> (resData[WIDE-1:HALF_W] == '0));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.capture |=> $stable(resData));
endmodule

// File: rtl/hp_xfer_unit.sv
module hp_xfer_unit
  import hp_xfer_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 64,
  localparam int WIDE = (XLEN > FLEN) ? XLEN : FLEN
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqOp,
  input  logic [2:0]      reqRm,
  input  logic [WIDE-1:0] srcData,
  output logic            resValid,
  output logic            illegal,
  output logic [WIDE-1:0] resData
);
  dpCtrl_t dpCtrl;

  initial begin
    if (!(XLEN == 32 || XLEN == 64) || !(FLEN == 32 || FLEN == 64))
      $error("hp_xfer_unit: XLEN and FLEN must each be 32 or 64");
  end

  hp_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqRm    (reqRm),
    .dpCtrl   (dpCtrl),
    .resValid (resValid),
    .illegal  (illegal)
  );

  hp_xfer_dp #(.XLEN(XLEN), .FLEN(FLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .srcData (srcData),
    .resData (resData)
  );
endmodule

// File: tb/hp_xfer_unit_test.sv
module hp_xfer_unit_test;
  localparam int XLEN = 64;
  localparam int FLEN = 64;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [2:0]   reqOp = 3'b000;
  logic [2:0]   reqRm = 3'b000;
  logic [W-1:0] srcData = '0;
  logic         resValid;
  logic         illegal;
  logic [W-1:0] resData;

  typedef struct {
    logic         v;
    logic         ill;
    logic [W-1:0] d;
    string        tag;
  } item_t;

  item_t        sbQ[$];
  int           errors = 0;
  int           checks = 0;
  logic [W-1:0] modelData = '0;

  always #10 clk = ~clk;

  hp_xfer_unit #(.XLEN(XLEN), .FLEN(FLEN)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqRm(reqRm), .srcData(srcData), .resValid(resValid),
    .illegal(illegal), .resData(resData)
  );

  task automatic send(input logic v, input logic [2:0] op, input logic [2:0] rm,
                      input logic [W-1:0] src, input string tag);
    item_t it;
    logic  ok;
    @(negedge clk);
    reqValid = v; reqOp = op; reqRm = rm; srcData = src;
    ok = (op <= 3'd3) && !((op == 3'd2 || op == 3'd3) && rm != 3'b000);
    if (v && ok) begin
      case (op)
        3'd0, 3'd3: modelData = {48'hFFFF_FFFF_FFFF, src[15:0]};
        3'd1:       modelData = {48'h0, src[15:0]};
        default:    modelData = {{48{src[15]}}, src[15:0]};
      endcase
    end
    it.v = v && ok; it.ill = v && !ok; it.d = modelData; it.tag = tag;
    sbQ.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sbQ.size() > 0) begin
      item_t e;
      e = sbQ.pop_front();
      checks++;
      if (resValid !== e.v || illegal !== e.ill || resData !== e.d) begin
        errors++;
        $display("FAIL %s: got v=%b ill=%b d=%h, expected v=%b ill=%b d=%h",
                 e.tag, resValid, illegal, resData, e.v, e.ill, e.d);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || illegal !== 1'b0 || resData !== '0) begin
      errors++;
      $display("FAIL R9 reset: got v=%b ill=%b d=%h, expected 0 0 0",
               resValid, illegal, resData);
    end
    rstN = 1'b1;
    send(1, 3'd0, 3'd0, 64'h1234_5678_9ABC_3C00, "R1 load one");
    send(1, 3'd0, 3'd7, 64'h0000_0000_0000_7E01, "R8 R5 load rm ignored qNaN");
    send(0, 3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 idle hold");
    send(1, 3'd1, 3'd0, 64'hDEAD_BEEF_1234_ABCD, "R3 store high ignored");
    send(1, 3'd1, 3'd5, 64'hFFFF_FFFF_FFFF_FC01, "R3 R5 store sNaN rm ignored");
    send(1, 3'd2, 3'd0, 64'h0000_0000_0000_8001, "R4 mv f2x negative");
    send(1, 3'd2, 3'd0, 64'hAAAA_5555_0F0F_7C00, "R4 mv f2x positive");
    send(1, 3'd3, 3'd0, 64'hFFFF_FFFF_0000_5555, "R2 mv x2f");
    send(1, 3'd3, 3'd0, 64'h0000_0000_0000_7D23, "R2 R5 mv x2f sNaN payload");
    send(1, 3'd2, 3'd1, 64'h0000_0000_0000_1111, "R6 mv f2x bad rm");
    send(1, 3'd3, 3'd4, 64'h0000_0000_0000_2222, "R6 mv x2f bad rm");
    send(1, 3'd5, 3'd0, 64'h0000_0000_0000_3333, "R7 undefined op");
    send(1, 3'd7, 3'd0, 64'h0000_0000_0000_4444, "R7 undefined op 7");
    send(1, 3'd2, 3'd0, 64'h0000_0000_0000_FE55, "R5 mv f2x neg qNaN");
    send(1, 3'd0, 3'd0, 64'h0000_0000_0000_0000, "R1 load zero");
    send(1, 3'd1, 3'd0, 64'h0000_0000_0000_FFFF, "R3 store ones");
    send(0, 3'd5, 3'd3, 64'h0, "R8 idle after store");
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL R8 scoreboard: got %0d pending, expected 0", sbQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule